// File: doc/BRIEF.md
# Windowed Exposure Statistics Accumulator

This block gathers luminance statistics for auto-exposure control from a pixel stream. Pixels arrive one per cycle when `pix_vld` is high. A one-cycle `hsync` pulse closes each line and a one-cycle `vsync` pulse closes each field. A rectangular statistics window can be set per axis; when an axis is not masked, the window on that axis spans the whole image. The window is cut into an 8 × 8 grid of blocks. Each block accumulates a luminance sum and a sample count. Along each line, the block also forms sums of short groups of consecutive in-window pixels and tracks the largest and the smallest group value seen in the field.

When `vsync` arrives, the field's totals are copied into a shadow store and the accumulators clear for the next field. A single shared divider then converts the 64 block totals to 8-bit averages, one block per cycle. The averages and the peak and valley values are read through a combinational address-to-data path. Firmware reads them between fields to steer exposure.

Top module: `exp_stats_acc`

## Requirements
- R1: After reset, every read address returns 00h until the first field has been latched and converted.
- R2: Column position is the count of valid samples since the last `hsync` (first sample = column 0). With `h_mask_en` high, only columns `h_start`..`h_end` inclusive are accumulated; with it low, columns 0..IMG_W-1 are.
- R3: Row position is the count of `hsync` pulses since the last `vsync` (first line = row 0). With `v_mask_en` high, only rows `v_start`..`v_end` inclusive are accumulated; with it low, rows 0..IMG_H-1 are.
- R4: With window width W, height H and origin (xl, yl), an in-window sample belongs to grid column floor(8·(x−xl)/W) and grid row floor(8·(y−yl)/H). Its block average is read at address row·8+column (00h = top-left).
- R5: With `avg_by_cnt` high at the closing `vsync`, a block's value is floor(sum / samples in that block), or 00h if the block received no samples.
- R6: With `avg_by_cnt` low, a block's value is floor(sum / ((W>>3)·(H>>3))), clamped to FFh, or 00h when that divisor is zero. W and H are the window sizes in effect at the closing `vsync`.
- R7: Groups are runs of 4 (`grp8_sel` low) or 8 (`grp8_sel` high) consecutive in-window samples in a line, counted from the window's left edge. A partial group at line end is dropped. Address 60h returns the largest group sum divided by the group size, rounded down.
- R8: Address 61h returns the smallest such group value. If the field completed no group, both 60h and 61h return 00h.
- R9: At `vsync` the field's results are captured. Addresses 60h and 61h update on the next cycle, and all block averages are in place within 66 cycles. All values then hold until the next `vsync`, regardless of the pixels streamed in between.
- R10: Addresses 40h–5Fh and 62h–7Fh return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync | input | 1 | Field-end pulse; latches results |
| hsync | input | 1 | Line-end pulse |
| pix_vld | input | 1 | Luminance sample valid |
| luma | input | 8 | Luminance sample |
| h_mask_en | input | 1 | Restrict columns to h_start..h_end |
| v_mask_en | input | 1 | Restrict rows to v_start..v_end |
| h_start | input | 10 | First window column |
| h_end | input | 10 | Last window column |
| v_start | input | 9 | First window row |
| v_end | input | 9 | Last window row |
| grp8_sel | input | 1 | Peak group size: 0 = 4 samples, 1 = 8 samples |
| avg_by_cnt | input | 1 | Average divisor: 1 = sample count, 0 = nominal block area |
| rd_addr | input | 7 | Readout address |
| rd_data | output | 8 | Readout data (combinational) |

## Verification
On every cycle, the assertions check the following. Peak never falls below valley once a group has completed. The running peak only rises within a field. A `vsync` always starts a conversion pass at block 0, and the pass ends after block 63. Latched peak and valley stay fixed between `vsync` pulses. Unmapped addresses read zero. The bench streams whole fields with gap cycles and compares every address against a model computed from the requirements. This covers the grid partition for windows whose sizes are not multiples of eight, both averaging modes including clamping and a zero divisor, both group sizes, the no-group case, and results holding while the next field streams. Only these scenarios can show those behaviours.

// File: rtl/exp_stats_pkg.sv
package exp_stats_pkg;
    localparam int GRID_LOG   = 3;
    localparam int GRID       = 1 << GRID_LOG;
    localparam int NBLK       = GRID * GRID;
    localparam int LUMA_W     = 8;
    localparam int BLK_W      = 2 * GRID_LOG;
    localparam logic [6:0] ADDR_PEAK   = 7'h60;
    localparam logic [6:0] ADDR_VALLEY = 7'h61;
endpackage

// File: rtl/exp_win_locator.sv
module exp_win_locator
    import exp_stats_pkg::*;
#(
    parameter int XW    = 10,
    parameter int YW    = 9,
    parameter int IMG_W = 640,
    parameter int IMG_H = 480
) (
    input  logic [XW-1:0]    x,
    input  logic [YW-1:0]    y,
    input  logic             h_mask_en,
    input  logic             v_mask_en,
    input  logic [XW-1:0]    h_start,
    input  logic [XW-1:0]    h_end,
    input  logic [YW-1:0]    v_start,
    input  logic [YW-1:0]    v_end,
    output logic             in_win,
    output logic [BLK_W-1:0] blk,
    output logic [XW:0]      win_w,
    output logic [YW:0]      win_h
);
    localparam int SXW = XW + GRID_LOG + 1;
    localparam int SYW = YW + GRID_LOG + 1;

    logic [XW-1:0] xlo, xhi, offx;
    logic [YW-1:0] ylo, yhi, offy;
    logic [GRID-2:0] tx, ty;

    always_comb begin
        xlo    = h_mask_en ? h_start : '0;
        xhi    = h_mask_en ? h_end   : XW'(IMG_W - 1);
        ylo    = v_mask_en ? v_start : '0;
        yhi    = v_mask_en ? v_end   : YW'(IMG_H - 1);
        win_w  = (xhi >= xlo) ? ({1'b0, xhi} - {1'b0, xlo} + 1'b1) : '0;
        win_h  = (yhi >= ylo) ? ({1'b0, yhi} - {1'b0, ylo} + 1'b1) : '0;
        offx   = x - xlo;
        offy   = y - ylo;
        in_win = (x >= xlo) && (x <= xhi) && (y >= ylo) && (y <= yhi);
    end

    // one threshold per interior grid boundary, on each axis
    for (genvar c = 1; c < GRID; c++) begin : g_thr
        assign tx[c-1] = (SXW'({offx, {GRID_LOG{1'b0}}}) >= SXW'(c) * SXW'(win_w));
        assign ty[c-1] = (SYW'({offy, {GRID_LOG{1'b0}}}) >= SYW'(c) * SYW'(win_h));
    end

    always_comb begin
        blk = {GRID_LOG'($countones(ty)), GRID_LOG'($countones(tx))};
    end
endmodule

// File: rtl/exp_peak_track.sv
module exp_peak_track
    import exp_stats_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              line_end,
    input  logic              smp,
    input  logic [LUMA_W-1:0] luma,
    input  logic              grp8,
    output logic [LUMA_W-1:0] peak,
    output logic [LUMA_W-1:0] valley
);
    typedef struct packed {
        logic [LUMA_W+2:0] gsum;
        logic [2:0]        gcnt;
        logic [LUMA_W-1:0] pk;
        logic [LUMA_W-1:0] vl;
        logic              any;
    } pk_st_t;

    localparam pk_st_t PK_RST = '{gsum: '0, gcnt: '0, pk: '0, vl: '1, any: 1'b0};

    pk_st_t q, d;
    logic [LUMA_W+2:0] nsum;
    logic [LUMA_W-1:0] scaled;
    logic              full;

    always_comb begin
        d      = q;
        nsum   = q.gsum + (LUMA_W+3)'(luma);
        full   = grp8 ? (q.gcnt == 3'd7) : (q.gcnt >= 3'd3);
        scaled = grp8 ? LUMA_W'(nsum >> 3) : LUMA_W'(nsum >> 2);
        if (clr) begin
            d = PK_RST;
        end else if (line_end) begin
            d.gsum = '0;
            d.gcnt = '0;
        end else if (smp) begin
            if (full) begin
                d.gsum = '0;
                d.gcnt = '0;
                d.any  = 1'b1;
                if (scaled > q.pk) d.pk = scaled;
                if (scaled < q.vl) d.vl = scaled;
            end else begin
                d.gsum = nsum;
                d.gcnt = q.gcnt + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= PK_RST;
        else        q <= d;
    end

    assign peak   = q.any ? q.pk : '0;
    assign valley = q.any ? q.vl : '0;

    p_peak_ge_valley_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.any |-> (q.pk >= q.vl));

    p_peak_monotone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> (q.pk >= $past(q.pk)));
endmodule

// File: rtl/exp_stats_acc.sv
module exp_stats_acc
    import exp_stats_pkg::*;
#(
    parameter int XW    = 10,
    parameter int YW    = 9,
    parameter int IMG_W = 640,
    parameter int IMG_H = 480,
    parameter int ACC_W = 24,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic              hsync,
    input  logic              pix_vld,
    input  logic [LUMA_W-1:0] luma,
    input  logic              h_mask_en,
    input  logic              v_mask_en,
    input  logic [XW-1:0]     h_start,
    input  logic [XW-1:0]     h_end,
    input  logic [YW-1:0]     v_start,
    input  logic [YW-1:0]     v_end,
    input  logic              grp8_sel,
    input  logic              avg_by_cnt,
    input  logic [6:0]        rd_addr,
    output logic [7:0]        rd_data
);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NBLK - 1);

    typedef struct packed {
        logic [XW-1:0]                 x;
        logic [YW-1:0]                 y;
        logic [NBLK-1:0][ACC_W-1:0]    sum;
        logic [NBLK-1:0][CNT_W-1:0]    cnt;
        logic [NBLK-1:0][ACC_W-1:0]    sh_sum;
        logic [NBLK-1:0][CNT_W-1:0]    sh_cnt;
        logic [NBLK-1:0][7:0]          avg;
        logic [ACC_W-1:0]              nom;
        logic                          by_cnt;
        logic                          busy;
        logic [BLK_W-1:0]              idx;
        logic [LUMA_W-1:0]             pk;
        logic [LUMA_W-1:0]             vl;
    } st_t;

    st_t q, d;

    logic             in_win, smp;
    logic [BLK_W-1:0] blk;
    logic [XW:0]      win_w;
    logic [YW:0]      win_h;
    logic [LUMA_W-1:0] trk_pk, trk_vl;
    logic [ACC_W-1:0] denom, quo;

    exp_win_locator #(.XW(XW), .YW(YW), .IMG_W(IMG_W), .IMG_H(IMG_H)) u_loc (
        .x(q.x), .y(q.y),
        .h_mask_en(h_mask_en), .v_mask_en(v_mask_en),
        .h_start(h_start), .h_end(h_end), .v_start(v_start), .v_end(v_end),
        .in_win(in_win), .blk(blk), .win_w(win_w), .win_h(win_h)
    );

    assign smp = pix_vld && in_win && !hsync && !vsync;

    exp_peak_track u_trk (
        .clk(clk), .rst_n(rst_n), .clr(vsync), .line_end(hsync),
        .smp(smp), .luma(luma), .grp8(grp8_sel),
        .peak(trk_pk), .valley(trk_vl)
    );

    always_comb begin
        d     = q;
        denom = q.by_cnt ? ACC_W'(q.sh_cnt[q.idx]) : q.nom;
        quo   = (denom == '0) ? '0 : (q.sh_sum[q.idx] / denom);

        // serial conversion pass: one block per cycle through the shared divider
        if (q.busy) begin
            d.avg[q.idx] = (quo > ACC_W'(255)) ? 8'hFF : quo[7:0];
            d.idx        = q.idx + 1'b1;
            if (q.idx == LAST_BLK) d.busy = 1'b0;
        end

        if (vsync) begin
            d.sh_sum = q.sum;
            d.sh_cnt = q.cnt;
            d.sum    = '0;
            d.cnt    = '0;
            d.nom    = ACC_W'(win_w >> GRID_LOG) * ACC_W'(win_h >> GRID_LOG);
            d.by_cnt = avg_by_cnt;
            d.busy   = 1'b1;
            d.idx    = '0;
            d.pk     = trk_pk;
            d.vl     = trk_vl;
            d.x      = '0;
            d.y      = '0;
        end else begin
            if (hsync) begin
                d.x = '0;
                d.y = q.y + 1'b1;
            end else if (pix_vld) begin
                d.x = q.x + 1'b1;
            end
            if (smp) begin
                d.sum[blk] = q.sum[blk] + ACC_W'(luma);
                d.cnt[blk] = q.cnt[blk] + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        if (!rd_addr[6])                rd_data = q.avg[rd_addr[BLK_W-1:0]];
        else if (rd_addr == ADDR_PEAK)   rd_data = q.pk;
        else if (rd_addr == ADDR_VALLEY) rd_data = q.vl;
        else                             rd_data = 8'h00;
    end

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[6] && rd_addr != ADDR_PEAK && rd_addr != ADDR_VALLEY) |-> (rd_data == 8'h00));

    p_conv_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> (q.busy && q.idx == '0));

    p_conv_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.idx == LAST_BLK && !vsync) |=> !q.busy);

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(vsync) |-> ($stable(q.pk) && $stable(q.vl)));
endmodule

// File: tb/exp_stats_acc_tb.sv
module exp_stats_acc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IW = 32;
    localparam int IH = 16;
    localparam int WD_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync = 1'b0, hsync = 1'b0, pix_vld = 1'b0;
    logic [7:0] luma = '0;
    logic       h_mask_en = 1'b0, v_mask_en = 1'b0;
    logic [9:0] h_start = '0, h_end = '0;
    logic [8:0] v_start = '0, v_end = '0;
    logic       grp8_sel = 1'b0, avg_by_cnt = 1'b1;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    int expv [128];
    int e_sum [64];
    int e_cnt [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    exp_stats_acc #(.IMG_W(IW), .IMG_H(IH)) u_dut (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync), .pix_vld(pix_vld),
        .luma(luma), .h_mask_en(h_mask_en), .v_mask_en(v_mask_en),
        .h_start(h_start), .h_end(h_end), .v_start(v_start), .v_end(v_end),
        .grp8_sel(grp8_sel), .avg_by_cnt(avg_by_cnt),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int lum(int x, int y, int s);
        return (x * 37 + y * 11 + s * 53 + (x * y) % 7) % 256;
    endfunction

    // expected results from the requirements (R2..R8, R10)
    task automatic model(int s);
        int xl, xh, yl, yh, w, h, n, pk, vl, anyg, nom;
        xl = h_mask_en ? int'(h_start) : 0;
        xh = h_mask_en ? int'(h_end)   : IW - 1;
        yl = v_mask_en ? int'(v_start) : 0;
        yh = v_mask_en ? int'(v_end)   : IH - 1;
        w = xh - xl + 1;
        h = yh - yl + 1;
        n = grp8_sel ? 8 : 4;
        pk = 0; vl = 255; anyg = 0;
        for (int b = 0; b < 64; b++) begin e_sum[b] = 0; e_cnt[b] = 0; end
        for (int y = yl; y <= yh && y < IH; y++) begin
            int gs, gc;
            gs = 0; gc = 0;
            for (int x = xl; x <= xh && x < IW; x++) begin
                int v, b;
                v = lum(x, y, s);
                b = ((8 * (y - yl)) / h) * 8 + (8 * (x - xl)) / w;
                e_sum[b] += v;
                e_cnt[b] += 1;
                gs += v; gc++;
                if (gc == n) begin
                    int g;
                    g = gs / n;
                    anyg = 1;
                    if (g > pk) pk = g;
                    if (g < vl) vl = g;
                    gs = 0; gc = 0;
                end
            end
        end
        nom = (w / 8) * (h / 8);
        for (int a = 0; a < 128; a++) expv[a] = 0;
        for (int b = 0; b < 64; b++) begin
            int dv, qv;
            dv = avg_by_cnt ? e_cnt[b] : nom;
            qv = (dv == 0) ? 0 : e_sum[b] / dv;
            expv[b] = (qv > 255) ? 255 : qv;
        end
        expv[8'h60] = anyg ? pk : 0;
        expv[8'h61] = anyg ? vl : 0;
    endtask

    task automatic check(int a, int e, string tag);
        @(negedge clk);
        rd_addr = 7'(a);
        #1;
        vectors++;
        if (int'(rd_data) != e) begin
            fails++;
            $display("FAIL %s addr=%02h actual=%02h expected=%02h", tag, a, rd_data, e);
        end
    endtask

    task automatic check_all(string tag_blk);
        for (int a = 0; a < 128; a++) begin
            if (a < 64)          check(a, expv[a], tag_blk);
            else if (a == 8'h60) check(a, expv[a], "R7 peak");
            else if (a == 8'h61) check(a, expv[a], "R8 valley");
            else                 check(a, 0, "R10 unmapped");
        end
    endtask

    task automatic stream_lines(int s, int y0, int y1);
        for (int y = y0; y <= y1; y++) begin
            for (int x = 0; x < IW; x++) begin
                if (x % 5 == 2) begin
                    @(negedge clk);
                    pix_vld = 1'b0; luma = 8'hFF;
                end
                @(negedge clk);
                pix_vld = 1'b1;
                luma = 8'(lum(x, y, s));
            end
            @(negedge clk);
            pix_vld = 1'b0; luma = 8'hFF; hsync = 1'b1;
            @(negedge clk);
            hsync = 1'b0;
        end
    endtask

    task automatic close_field();
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
        repeat (70) @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: nothing latched yet
        check(8'h00, 0, "R1 reset");
        check(8'h3F, 0, "R1 reset");
        check(8'h60, 0, "R1 reset");
        check(8'h61, 0, "R1 reset");

        // field A: no masking, count averages, groups of 4 (R2 R3 R4 R5 R7 R8)
        h_mask_en = 0; v_mask_en = 0; grp8_sel = 0; avg_by_cnt = 1;
        stream_lines(1, 0, IH - 1);
        close_field();
        model(1);
        check_all("R4 R5 full image");

        // field B: window 20x12 (uneven grid), count averages, groups of 8
        h_mask_en = 1; h_start = 10'd4; h_end = 10'd23;
        v_mask_en = 1; v_start = 9'd2;  v_end = 9'd13;
        grp8_sel = 1; avg_by_cnt = 1;
        stream_lines(2, 0, IH - 1);
        close_field();
        model(2);
        check_all("R2 R3 R4 R5 window");

        // field C: same window, nominal divisor, groups of 4; mid-field hold check
        grp8_sel = 0; avg_by_cnt = 0;
        stream_lines(3, 0, 7);
        check(0,     expv[0],     "R9 hold");
        check(27,    expv[27],    "R9 hold");
        check(63,    expv[63],    "R9 hold");
        check(8'h60, expv[8'h60], "R9 hold");
        check(8'h61, expv[8'h61], "R9 hold");
        stream_lines(3, 8, IH - 1);
        close_field();
        model(3);
        check_all("R6 nominal clamp");

        // field D: 2-column window, nominal divisor is zero, no complete group of 8
        h_mask_en = 1; h_start = 10'd30; h_end = 10'd31;
        v_mask_en = 0; grp8_sel = 1; avg_by_cnt = 0;
        stream_lines(4, 0, IH - 1);
        close_field();
        model(4);
        check_all("R6 zero divisor");

        // field E: single-row vertical window, full width, count averages
        h_mask_en = 0; v_mask_en = 1; v_start = 9'd15; v_end = 9'd15;
        grp8_sel = 0; avg_by_cnt = 1;
        stream_lines(5, 0, IH - 1);
        close_field();
        model(5);
        check_all("R3 R5 single row");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule